// File: doc/BRIEF.md
# Reset-Strapped Test Mode Controller

This block chooses the operating mode of an audio codec from two strap values. The straps are the levels on the frame-sync pin and on the host-to-codec serial data pin when the active-low cold reset is released. The mode is latched once and then held until the next cold reset. After that point the pins return to their ordinary link duties, and nothing they carry can move the mode.

The latched mode controls the pad enables. In board-level in-circuit test mode, every digital output of the codec floats and every internal pull-up is switched off. This lets a tester on the board drive the link from outside, or lets a second codec act as the primary. The reserved code also floats the pads. Normal mode and the internal test mode keep the ordinary enables, which are set by parameters. The three no-connect pins never drive in any mode.

Top module: `smc_strap_ctrl`

## Requirements
- R1: While `rst_ni` is low, `mode_o` reads 00, `pad_oe_o` equals `NORMAL_OE` and `pad_pu_en_o` equals `NORMAL_PU`.
- R2: With the straps held steady across the release of `rst_ni`, `mode_o` stays 00 up to and including the second rising clock edge after release. It shows the captured code after the third edge, which is `RST_STAGES`+1 edges.
- R3: The captured code is {sync strap, serial-data strap}. 00 selects normal operation, 01 selects board in-circuit test, 10 selects internal test and 11 is reserved.
- R4: In board-test mode (01), every bit of `pad_oe_o` and every bit of `pad_pu_en_o` is 0.
- R5: With `RESERVED_HIZ`=1, the reserved code 11 is latched as a non-normal mode, and `pad_oe_o` and `pad_pu_en_o` are all 0, as in board-test mode.
- R6: In internal test mode (10), `pad_oe_o` equals `NORMAL_OE` and `pad_pu_en_o` equals `NORMAL_PU`.
- R7: Once captured, the mode does not change for any activity on either strap pin, including pulses on the sync pin, until `rst_ni` goes low again.
- R8: A test mode is left only through a new cold reset. Releasing that reset with both straps low returns `mode_o` to 00 and restores the normal enables.
- R9: `nc_oe_o` is all 0 in every mode and during reset.
- R10: The bits of `pad_oe_o` map to pins as follows: bit 0 is the bit clock, bit 1 is the codec-to-host serial data, the next `N_GPIO` bits are the general-purpose pins, the next `N_CID` bits are the codec-ID pins, then comes the amplifier power-down pin, and the top bit is the digital audio output. `pad_pu_en_o` uses the same order and adds two bits above it, for the sync pin and then the serial-data pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low cold reset, asserted asynchronously |
| sync_strap_i | input | 1 | Level of the frame-sync pin, sampled as a strap |
| sdo_strap_i | input | 1 | Level of the host-to-codec serial data pin, sampled as a strap |
| mode_o | output | 2 | Latched mode code {sync, serial data} |
| pad_oe_o | output | N_GPIO+N_CID+4 | Output enables for the codec's digital output pins |
| pad_pu_en_o | output | N_GPIO+N_CID+6 | Pull-up enables for the digital I/O pins |
| nc_oe_o | output | N_NC | Output enables for the no-connect pins |

## Verification
The bench builds the block with two general-purpose pins, two ID pins, two-stage strap and reset synchronizers and the reserved code floating the pads. It overrides the normal enables with the irregular patterns 8'hBF and 10'h2A5. With those patterns, a swapped or shifted pad bit, or a mode that leaves the wrong pins driven, shows up as a vector mismatch. The three-edge capture latency and a reset that is pulled again before capture finishes are both within reach. The bench also returns from every non-normal code through a fresh reset.

// File: rtl/smc_pkg.sv
package smc_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL   = 2'b00,
      MODE_BOARD    = 2'b01,
      MODE_INTERNAL = 2'b10,
      MODE_RESERVED = 2'b11
   } smc_mode_e;

   // Strap order: sync is the upper bit, serial data the lower bit.
   function automatic smc_mode_e smc_decode(input logic sync_v, input logic sdo_v);
      return smc_mode_e'({sync_v, sdo_v});
   endfunction

   // Fixed pad lanes ahead of the parameterised groups.
   localparam int unsigned LANE_BITCLK = 0;
   localparam int unsigned LANE_SDIN   = 1;
   localparam int unsigned FIXED_LANES = 4;

endpackage

// File: rtl/smc_bit_sync.sv
module smc_bit_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("smc_bit_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("smc_bit_sync: WIDTH must be at least 1");
   end

   // One flop chain per strap bit. No reset, so the straps keep
   // flowing while the block is held in reset.
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i) begin
         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain_q[STAGES-1];
   end
endmodule

// File: rtl/smc_rst_sync.sv
module smc_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic rel_no
);
   if (STAGES < 2) begin : g_bad_stages
      $error("smc_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff_q;

   // Asserted asynchronously, released in step with the clock.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '0;
      else         ff_q <= {ff_q[STAGES-2:0], 1'b1};
   end

   assign rel_no = ff_q[STAGES-1];
endmodule

// File: rtl/smc_mode_latch.sv
module smc_mode_latch
   import smc_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      rel_ni,
   input  logic      sync_s_i,
   input  logic      sdo_s_i,
   output smc_mode_e mode_o,
   output logic      locked_o
);
   smc_mode_e mode_q;
   logic      locked_q;

   // The capture happens on the first edge that sees the synchronised
   // release. After that the lock flag stops any further load until
   // the next cold reset.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q   <= MODE_NORMAL;
         locked_q <= 1'b0;
      end else if (rel_ni && !locked_q) begin
         mode_q   <= smc_decode(sync_s_i, sdo_s_i);
         locked_q <= 1'b1;
      end
   end

   assign mode_o   = mode_q;
   assign locked_o = locked_q;
endmodule

// File: rtl/smc_pad_ctrl.sv
module smc_pad_ctrl
   import smc_pkg::*;
#(
   parameter int unsigned     N_OUT        = 8,
   parameter int unsigned     N_PU         = 10,
   parameter int unsigned     N_NC         = 3,
   parameter logic [N_OUT-1:0] NORMAL_OE   = '1,
   parameter logic [N_PU-1:0]  NORMAL_PU   = '1,
   parameter bit              RESERVED_HIZ = 1'b1
) (
   input  smc_mode_e        mode_i,
   output logic [N_OUT-1:0] pad_oe_o,
   output logic [N_PU-1:0]  pad_pu_en_o,
   output logic [N_NC-1:0]  nc_oe_o
);
   logic release_pads;

   // The variant is chosen by parameter: whether the reserved code
   // also floats the pads.
   if (RESERVED_HIZ) begin : g_res_hiz
      assign release_pads = (mode_i == MODE_BOARD) || (mode_i == MODE_RESERVED);
   end else begin : g_res_drive
      assign release_pads = (mode_i == MODE_BOARD);
   end

   for (genvar i = 0; i < N_OUT; i++) begin : g_oe
      assign pad_oe_o[i] = NORMAL_OE[i] & ~release_pads;
   end

   for (genvar j = 0; j < N_PU; j++) begin : g_pu
      assign pad_pu_en_o[j] = NORMAL_PU[j] & ~release_pads;
   end

   // The no-connect pins are inputs only.
   assign nc_oe_o = '0;
endmodule

// File: rtl/smc_strap_ctrl.sv
module smc_strap_ctrl
   import smc_pkg::*;
#(
   parameter int unsigned N_GPIO       = 2,
   parameter int unsigned N_CID        = 2,
   parameter int unsigned N_NC         = 3,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned RST_STAGES   = 2,
   parameter logic [N_GPIO+N_CID+3:0] NORMAL_OE = '1,
   parameter logic [N_GPIO+N_CID+5:0] NORMAL_PU = '1,
   parameter bit          RESERVED_HIZ = 1'b1
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     sync_strap_i,
   input  logic                     sdo_strap_i,
   output logic [1:0]               mode_o,
   output logic [N_GPIO+N_CID+3:0]  pad_oe_o,
   output logic [N_GPIO+N_CID+5:0]  pad_pu_en_o,
   output logic [N_NC-1:0]          nc_oe_o
);
   localparam int unsigned N_OUT      = N_GPIO + N_CID + FIXED_LANES;
   localparam int unsigned N_PU       = N_OUT + 2;
   localparam int unsigned LANE_GPIO0 = 2;
   localparam int unsigned LANE_CID0  = LANE_GPIO0 + N_GPIO;
   localparam int unsigned LANE_AMPPD = LANE_CID0 + N_CID;
   localparam int unsigned LANE_SPDO  = LANE_AMPPD + 1;

   if (N_GPIO < 1 || N_CID < 1 || N_NC < 1) begin : g_bad_counts
      $error("smc_strap_ctrl: pin group counts must be at least 1");
   end
   if (LANE_SPDO != N_OUT - 1 || LANE_BITCLK != 0 || LANE_SDIN != 1) begin : g_bad_map
      $error("smc_strap_ctrl: pad lane map inconsistent");
   end

   logic [1:0] strap_s;
   logic       rel_n;
   logic       locked;
   smc_mode_e  mode;

   smc_bit_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES)
   ) u_strap_sync (
      .clk_i (clk_i),
      .d_i   ({sync_strap_i, sdo_strap_i}),
      .q_o   (strap_s)
   );

   smc_rst_sync #(
      .STAGES (RST_STAGES)
   ) u_rst_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rel_no (rel_n)
   );

   smc_mode_latch u_latch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rel_ni   (rel_n),
      .sync_s_i (strap_s[1]),
      .sdo_s_i  (strap_s[0]),
      .mode_o   (mode),
      .locked_o (locked)
   );

   smc_pad_ctrl #(
      .N_OUT        (N_OUT),
      .N_PU         (N_PU),
      .N_NC         (N_NC),
      .NORMAL_OE    (NORMAL_OE),
      .NORMAL_PU    (NORMAL_PU),
      .RESERVED_HIZ (RESERVED_HIZ)
   ) u_pads (
      .mode_i      (mode),
      .pad_oe_o    (pad_oe_o),
      .pad_pu_en_o (pad_pu_en_o),
      .nc_oe_o     (nc_oe_o)
   );

   assign mode_o = mode;
endmodule

// File: rtl/smc_strap_ctrl_chk.sv
module smc_strap_ctrl_chk #(
   parameter int unsigned      N_OUT        = 8,
   parameter int unsigned      N_PU         = 10,
   parameter logic [N_OUT-1:0] NORMAL_OE    = '1,
   parameter logic [N_PU-1:0]  NORMAL_PU    = '1,
   parameter bit               RESERVED_HIZ = 1'b1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             locked_i,
   input logic [1:0]       mode_o,
   input logic [N_OUT-1:0] pad_oe_o,
   input logic [N_PU-1:0]  pad_pu_en_o
);
   always @(posedge clk_i) begin
      if (!rst_ni) begin
         a_r1_reset_normal: assert (mode_o == 2'b00 && pad_oe_o == NORMAL_OE
                                    && pad_pu_en_o == NORMAL_PU)
            else $error("R1: state not normal during reset");
      end
   end

   a_r2_normal_until_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !locked_i |-> mode_o == 2'b00);

   a_r7_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locked_i |=> (locked_i && $stable(mode_o)));

   a_r4_board_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_o == 2'b01 |-> (pad_oe_o == '0 && pad_pu_en_o == '0));

   a_r5_reserved_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (RESERVED_HIZ && mode_o == 2'b11) |-> (pad_oe_o == '0 && pad_pu_en_o == '0));

   a_r6_internal_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_o == 2'b10 |-> (pad_oe_o == NORMAL_OE && pad_pu_en_o == NORMAL_PU));
endmodule

bind smc_strap_ctrl smc_strap_ctrl_chk #(
   .N_OUT        (N_OUT),
   .N_PU         (N_PU),
   .NORMAL_OE    (NORMAL_OE),
   .NORMAL_PU    (NORMAL_PU),
   .RESERVED_HIZ (RESERVED_HIZ)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .locked_i    (locked),
   .mode_o      (mode_o),
   .pad_oe_o    (pad_oe_o),
   .pad_pu_en_o (pad_pu_en_o)
);

// File: tb/smc_strap_ctrl_tb.sv
module smc_strap_ctrl_tb_top;
   localparam int unsigned N_GPIO = 2;
   localparam int unsigned N_CID  = 2;
   localparam int unsigned N_NC   = 3;
   localparam int unsigned SYNC_STAGES = 2;
   localparam int unsigned RST_STAGES  = 2;
   localparam int unsigned N_OUT  = N_GPIO + N_CID + 4;
   localparam int unsigned N_PU   = N_OUT + 2;
   localparam logic [N_OUT-1:0] OE_NORM = 8'hBF;
   localparam logic [N_PU-1:0]  PU_NORM = 10'h2A5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_s = 1'b0;
   logic sdo_s = 1'b0;
   logic [1:0]       mode;
   logic [N_OUT-1:0] oe;
   logic [N_PU-1:0]  pu;
   logic [N_NC-1:0]  nc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   smc_strap_ctrl #(
      .N_GPIO (N_GPIO), .N_CID (N_CID), .N_NC (N_NC),
      .SYNC_STAGES (SYNC_STAGES), .RST_STAGES (RST_STAGES),
      .NORMAL_OE (OE_NORM), .NORMAL_PU (PU_NORM), .RESERVED_HIZ (1'b1)
   ) dut_i (
      .clk_i (clk), .rst_ni (rst_n),
      .sync_strap_i (sync_s), .sdo_strap_i (sdo_s),
      .mode_o (mode), .pad_oe_o (oe), .pad_pu_en_o (pu), .nc_oe_o (nc)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Reference model: a history of strap levels and a count of edges since release.
   bit [1:0] hist[$];
   int       edges_since_rel = 0;
   bit [1:0] ref_mode = 2'b00;
   bit       ref_lock = 1'b0;

   always @(posedge clk) begin
      hist.push_front({sync_s, sdo_s});
      if (hist.size() > 8) void'(hist.pop_back());
      if (!rst_n) begin
         edges_since_rel = 0;
         ref_mode = 2'b00;
         ref_lock = 1'b0;
      end else begin
         edges_since_rel++;
         if (edges_since_rel == RST_STAGES + 1 && !ref_lock) begin
            ref_mode = hist[SYNC_STAGES];
            ref_lock = 1'b1;
         end
      end
   end

   // Every-clock comparison, 2 ns after the edge.
   always @(posedge clk) begin
      #2;
      if (!done) begin
         logic [1:0] em;
         bit rel;
         em  = rst_n ? ref_mode : 2'b00;
         rel = (em == 2'b01) || (em == 2'b11);
         chk(mode == em, rst_n ? "R2" : "R1", "mode_o", 32'(mode), 32'(em));
         chk(oe == (rel ? '0 : OE_NORM), rel ? "R4" : "R6", "pad_oe_o",
             32'(oe), 32'(rel ? '0 : OE_NORM));
         chk(pu == (rel ? '0 : PU_NORM), rel ? "R4" : "R10", "pad_pu_en_o",
             32'(pu), 32'(rel ? '0 : PU_NORM));
         chk(nc == '0, "R9", "nc_oe_o", 32'(nc), 32'd0);
      end
   end

   task automatic cold_reset(input bit [1:0] code, input int low_cycles);
      @(negedge clk);
      rst_n  = 1'b0;
      sync_s = code[1];
      sdo_s  = code[0];
      repeat (low_cycles) @(negedge clk);
      chk(mode == 2'b00 && oe == OE_NORM && pu == PU_NORM, "R1", "reset state",
          32'(mode), 32'd0);
      rst_n = 1'b1;
      // Edges 1 and 2 after release: still normal.
      @(negedge clk);
      @(negedge clk);
      chk(mode == 2'b00, "R2", "before capture", 32'(mode), 32'd0);
      @(negedge clk);
      chk(mode == code, "R3", "captured code", 32'(mode), 32'(code));
      repeat (3) @(negedge clk);
   endtask

   task automatic wiggle_straps(input bit [1:0] held);
      for (int i = 0; i < 14; i++) begin
         @(negedge clk);
         sync_s = i[0];
         sdo_s  = i[1] ^ i[2];
      end
      // Warm-reset style pulse on sync.
      @(negedge clk); sync_s = 1'b1;
      repeat (4) @(negedge clk);
      sync_s = 1'b0; sdo_s = 1'b0;
      repeat (2) @(negedge clk);
      chk(mode == held, "R7", "mode after strap activity", 32'(mode), 32'(held));
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(mode == 2'b00 && nc == '0, "R1", "initial reset", 32'(mode), 32'd0);

      cold_reset(2'b00, 3);
      chk(oe == OE_NORM, "R10", "normal oe lanes", 32'(oe), 32'(OE_NORM));
      chk(pu == PU_NORM, "R10", "normal pull-up lanes", 32'(pu), 32'(PU_NORM));
      wiggle_straps(2'b00);

      cold_reset(2'b01, 4);
      chk(oe == '0 && pu == '0, "R4", "board test floats pads", 32'(oe), 32'd0);
      wiggle_straps(2'b01);
      chk(nc == '0, "R9", "nc in board test", 32'(nc), 32'd0);

      cold_reset(2'b10, 2);
      chk(oe == OE_NORM && pu == PU_NORM, "R6", "internal test keeps enables",
          32'(oe), 32'(OE_NORM));
      wiggle_straps(2'b10);

      cold_reset(2'b11, 3);
      chk(oe == '0 && pu == '0, "R5", "reserved floats pads", 32'(pu), 32'd0);
      wiggle_straps(2'b11);

      cold_reset(2'b00, 3);
      chk(mode == 2'b00 && oe == OE_NORM, "R8", "return to normal", 32'(mode), 32'd0);

      // Reset pulled again before capture completes.
      @(negedge clk);
      rst_n = 1'b0; sync_s = 1'b0; sdo_s = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(mode == 2'b00, "R1", "aborted capture", 32'(mode), 32'd0);
      cold_reset(2'b01, 2);
      cold_reset(2'b00, 2);
      chk(mode == 2'b00 && pu == PU_NORM, "R8", "exit board test", 32'(mode), 32'd0);

      repeat (5) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule